// File: doc/BRIEF.md
# Processor Time Base and Decrementer

This unit keeps two timers for a processor core. One is a 64-bit time base that counts up and never stops. The other is a 32-bit decrementer that counts down. Both move by one step in each cycle where the external `tick` enable is high. The time base appears to software as a lower word and an upper word. Software can read and write the lower word, the upper word and the decrementer through a small register port. Each access uses a select field and separate read and write strobes.

The unit sets a timer interrupt request whenever bit 31 of the decrementer goes from clear to set. This happens in two cases: the count passes through zero, or software writes a negative value over a non-negative one. The request stays pending until the core pulses the acknowledge input. The core handles masking and vectoring of the request.

Top module: `timebase_decr`

## Requirements
- R1: After reset the time base reads 0 and the decrementer reads 0xFFFFFFFF. `irq` is 0 and `rdata` is 0.
- R2: In a cycle with `tick` high, the 64-bit time base goes up by one, and a carry from the lower word reaches the upper word. With `tick` low and no write, it keeps its value.
- R3: In a cycle with `tick` high, the decrementer goes down by one. With `tick` low and no write, it keeps its value.
- R4: If a tick arrives while the decrementer holds 0, the decrementer becomes 0xFFFFFFFF and `irq` is set on the next cycle.
- R5: A write to the decrementer (`sel`=2) sets `irq` only when bit 31 of `wdata` is 1 and bit 31 of the current value is 0. Other decrementer writes do not set it.
- R6: A write with `sel`=0 replaces time base bits 31:0 and keeps bits 63:32. A write with `sel`=1 replaces bits 63:32 and keeps bits 31:0.
- R7: A write takes priority over a tick in the same cycle, but only for the register being written. That register takes the written value, and the other registers still count.
- R8: `irq` stays set until `irq_ack` is high at a clock edge. If a new set happens in the same cycle as `irq_ack`, `irq` stays 1.
- R9: When `rd` is high at a clock edge, `rdata` captures the value the selected register held before that edge. `sel`=0 returns the lower word, 1 the upper word, 2 the decrementer and 3 returns zero. Without `rd`, `rdata` keeps its value.
- R10: A write with `sel`=3 changes no register.
- R11: Writing 0 to the decrementer does not set `irq` in that cycle. The next tick wraps the count and sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time base step enable |
| sel | input | 2 | Register select: 0 lower TB, 1 upper TB, 2 decrementer, 3 none |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq_ack | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Sticky timer interrupt request |

## Verification
Two pairs of events can fall in the same cycle: a register write with a tick, and an interrupt set with an acknowledge. The bench forces both on purpose. It writes the decrementer and the upper time base word while `tick` is high. It ticks through zero while `irq_ack` is asserted. A random phase then mixes all the inputs freely. On every clock, a behavioural reference model in the bench judges `irq` and `rdata`, and the counters are read back through the register port.

// File: rtl/timebase_decr.sv
module timebase_decr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  input  logic          irq_ack,
  output logic          irq
);
  localparam int TBW = 2 * DW;

  logic [TBW-1:0] tb;
  logic [DW-1:0]  dec;
  logic [DW-1:0]  rmux;

  wire wr_lo  = wr && (sel == 2'd0);
  wire wr_hi  = wr && (sel == 2'd1);
  wire wr_dec = wr && (sel == 2'd2);

  wire dec_wrap = tick && !wr_dec && (dec == '0);
  wire dec_neg  = wr_dec && wdata[DW-1] && !dec[DW-1];
  wire irq_set  = dec_wrap || dec_neg;

  always_comb begin
    case (sel)
      2'd0:    rmux = tb[DW-1:0];
      2'd1:    rmux = tb[TBW-1:DW];
      2'd2:    rmux = dec;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb    <= '0;
      dec   <= '1;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_lo)       tb <= {tb[TBW-1:DW], wdata};
      else if (wr_hi)  tb <= {wdata, tb[DW-1:0]};
      else if (tick)   tb <= tb + 1'b1;

      if (wr_dec)      dec <= wdata;
      else if (tick)   dec <= dec - 1'b1;

      if (irq_set)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;

      if (rd) rdata <= rmux;
    end
  end

  AST_TB_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr) |=> (tb == $past(tb) + 1'b1));                        // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> ($stable(tb) && $stable(dec)));                  // R3
  AST_DEC_STEP:  assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr) |=> (dec == $past(dec) - 1'b1));                      // R3
  AST_WRAP_IRQ:  assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && dec == '0) |=> (irq && dec == '1));                  // R4
  AST_NEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd2 && wdata[DW-1] && !dec[DW-1]) |=> irq);           // R5
  AST_WR_WINS:   assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd2) |=> (dec == $past(wdata)));                     // R7
  AST_IRQ_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);                                         // R8
  AST_RD_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));                                            // R9
  AST_NULL_WR:   assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd3 && !tick) |=> ($stable(tb) && $stable(dec)));    // R10
endmodule

// File: tb/sim_timebase_decr.sv
`timescale 1ns/1ps
module sim_timebase_decr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, wr = 0, rd = 0, irq_ack = 0;
  logic [1:0]  sel = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0, cyc = 0;

  logic [63:0] m_tb;
  logic [31:0] m_dec, m_rd;
  logic        m_irq;

  always #2.5 clk = ~clk;

  timebase_decr u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr(wr),
    .wdata(wdata), .rd(rd), .rdata(rdata), .irq_ack(irq_ack), .irq(irq));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d expected<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(bit t, bit w, logic [1:0] s, logic [31:0] d, bit r, bit a);
    bit setf;
    tick = t; wr = w; sel = s; wdata = d; rd = r; irq_ack = a;
    if (r) begin
      if (s == 2'd0) m_rd = m_tb[31:0];
      else if (s == 2'd1) m_rd = m_tb[63:32];
      else if (s == 2'd2) m_rd = m_dec;
      else m_rd = 0;
    end
    setf = 0;
    if (w && s == 2'd2) begin
      if (d[31] && !m_dec[31]) setf = 1;
      m_dec = d;
    end else if (t) begin
      if (m_dec == 0) setf = 1;
      m_dec = m_dec - 1;
    end
    if (w && s == 2'd0) m_tb[31:0] = d;
    else if (w && s == 2'd1) m_tb[63:32] = d;
    else if (t) m_tb = m_tb + 1;
    if (setf) m_irq = 1; else if (a) m_irq = 0;
    @(negedge clk);
    chk("R8 irq", {63'd0, irq}, {63'd0, m_irq});
    chk("R9 rdata", {32'd0, rdata}, {32'd0, m_rd});
  endtask

  task automatic rdchk(string req, logic [1:0] s, logic [31:0] exp);
    step(0, 0, s, 0, 1, 0);
    chk(req, {32'd0, rdata}, {32'd0, exp});
  endtask

  initial begin
    m_tb = 0; m_dec = 32'hFFFF_FFFF; m_rd = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rdata", {32'd0, rdata}, 0);
    chk("R1 irq", {63'd0, irq}, 0);
    rdchk("R1 dec", 2'd2, 32'hFFFF_FFFF);
    rdchk("R1 tbu", 2'd1, 0);

    repeat (5) step(1, 0, 0, 0, 0, 0);
    rdchk("R2 tbl", 2'd0, 5);
    rdchk("R3 dec", 2'd2, 32'hFFFF_FFFA);
    chk("R3 no irq", {63'd0, irq}, 0);

    step(0, 1, 2'd0, 32'hFFFF_FFFE, 0, 0);
    rdchk("R6 tbu kept", 2'd1, 0);
    step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
    rdchk("R2 carry", 2'd1, 1);
    rdchk("R2 low", 2'd0, 0);
    step(0, 1, 2'd1, 32'h1234_5678, 0, 0);
    rdchk("R6 tbl kept", 2'd0, 0);
    rdchk("R6 tbu", 2'd1, 32'h1234_5678);

    step(0, 1, 2'd2, 3, 0, 0);
    chk("R5 pos write", {63'd0, irq}, 0);
    repeat (3) step(1, 0, 0, 0, 0, 0);
    chk("R4 at zero", {63'd0, irq}, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R4 wrap irq", {63'd0, irq}, 1);
    rdchk("R4 wrap val", 2'd2, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 0, 0);
    chk("R8 sticky", {63'd0, irq}, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 ack", {63'd0, irq}, 0);

    step(0, 1, 2'd2, 32'h9000_0000, 0, 0);
    chk("R5 neg over neg", {63'd0, irq}, 0);
    step(0, 1, 2'd2, 5, 0, 0);
    step(0, 1, 2'd2, 32'h8000_0000, 0, 0);
    chk("R5 neg over pos", {63'd0, irq}, 1);
    step(0, 0, 0, 0, 0, 1);

    step(1, 1, 2'd2, 32'h0000_0100, 0, 0);
    rdchk("R7 dec wins", 2'd2, 32'h0000_0100);
    step(1, 1, 2'd1, 32'hAAAA_0000, 0, 0);
    rdchk("R7 tbu wins", 2'd1, 32'hAAAA_0000);
    rdchk("R7 dec counted", 2'd2, 32'h0000_00FF);

    step(0, 1, 2'd3, 32'hDEAD_BEEF, 0, 0);
    rdchk("R10 tbl", 2'd0, m_tb[31:0]);
    rdchk("R10 tbu", 2'd1, 32'hAAAA_0000);
    rdchk("R10 dec", 2'd2, 32'h0000_00FF);
    rdchk("R9 sel3", 2'd3, 0);

    step(0, 1, 2'd2, 0, 0, 0);
    chk("R11 no same-cycle", {63'd0, irq}, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R11 next tick", {63'd0, irq}, 1);
    step(0, 1, 2'd2, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1);
    chk("R8 set beats ack", {63'd0, irq}, 1);
    step(0, 0, 0, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 4) == 0) d = $urandom % 3;
      step($urandom % 2, ($urandom % 5) == 0, $urandom % 4, d,
           $urandom % 2, ($urandom % 4) == 0);
    end
    rdchk("R2 final tbl", 2'd0, m_tb[31:0]);
    rdchk("R2 final tbu", 2'd1, m_tb[63:32]);
    rdchk("R3 final dec", 2'd2, m_dec);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule